// File: doc/BRIEF.md
# HDB3 Line Encoder

This block turns a serial NRZ bit stream into the two-rail form of the HDB3 pseudo-ternary line code. One rail carries positive marks and the other carries negative marks. A one is sent as a mark whose polarity is the opposite of the mark before it. A run of four zeros is never sent as it is. Its last zero becomes a violation, which is a mark with the same polarity as the mark before it. When the last mark and the last violation share a polarity, the first zero of the run also becomes a normal alternating mark. This keeps successive violations alternating in polarity, so the line carries no DC component.

The block samples input data on the falling clock edge and passes it through a four-symbol window. The window lets a substitution pulse be placed at the start of a zero run. The choice between a bare violation and a leading pulse plus violation is made as that first position leaves the window, using the polarity state at that moment. Output pulses are return-to-zero: a rail is high only during the high phase of the clock. A bit appears on the rails four and a half clock periods after the falling edge that sampled it. Reset is synchronous and active high.

Top module: `hdb3_line_encoder`

## Requirements
- R1: While reset is asserted, and in the first high phase after a rising edge at which reset was high, both rails are low. Reset sets the last-mark polarity to negative and the last-violation polarity to positive.
- R2: An input one is sent as a single mark whose polarity is the opposite of the previous mark. The first mark after reset is therefore positive (on the positive rail).
- R3: In every run of four consecutive input zeros, the fourth zero is sent as a violation whose polarity equals the previous mark. No four consecutive zero symbols ever reach the output.
- R4: When the last mark and the last violation have the same polarity as a zero run completes, the first zero of the run is sent as a mark opposite to the previous mark, giving the pattern B00V.
- R5: When the last mark and the last violation differ, the run is sent as 000V. With no mark since reset, four zeros give a negative violation on the fourth position.
- R6: Successive violations always alternate in polarity.
- R7: A bit sampled at a falling clock edge appears on the rails during the high phase that follows the fifth rising edge after that sample, which is 4.5 clock periods later.
- R8: Output is return-to-zero: both rails are low during every low phase of the clock.
- R9: The two rails are never high at the same time.
- R10: An inserted B pulse updates the last-mark polarity in the same way as a data mark, so the next one or violation takes its polarity from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Encoder clock; data sampled on falling edge, pulses during high phase |
| rst | input | 1 | Synchronous active-high reset |
| nrz_i | input | 1 | Serial NRZ data to encode |
| pos_rail_o | output | 1 | Positive-mark rail, return-to-zero |
| neg_rail_o | output | 1 | Negative-mark rail, return-to-zero |

## Verification
The bench builds the encoder with its default run length of four, which is the substitution length of HDB3. At that size the window is short enough that patterns of a few bits reach every substitution path: the bare violation straight after reset, a B00V that follows a single one, back-to-back zero runs that force violations to alternate, and a zero run that is completed only by the trailing padding after a pattern. A long pseudo-random stream weighted towards zeros then mixes these cases with arbitrary mark parity. Each output symbol is compared in its exact high phase against a sequential model of the code.

// File: rtl/hdb3_pkg.sv
package hdb3_pkg;
  // Symbol codes carried through the look-ahead window.
  typedef enum logic [2:0] {
    SYM_IDLE = 3'd0,  // filler after reset, never counted as a zero
    SYM_ZERO = 3'd1,  // plain data zero
    SYM_ONE  = 3'd2,  // data one, sent as an alternating mark
    SYM_SUB  = 3'd3,  // head of a zero run: B or 0, decided on output
    SYM_VIOL = 3'd4   // tail of a zero run: violation
  } sym_t;
endpackage

// File: rtl/hdb3_sampler.sv
module hdb3_sampler (
  input  logic clk,
  input  logic rst,
  input  logic nrz_i,
  output logic bit_o,
  output logic vld_o
);
  // Input data is taken on the falling edge of the encoder clock.
  always_ff @(negedge clk) begin
    if (rst) begin
      bit_o <= 1'b0;
      vld_o <= 1'b0;
    end else begin
      bit_o <= nrz_i;
      vld_o <= 1'b1;
    end
  end
endmodule

// File: rtl/hdb3_lookahead.sv
module hdb3_lookahead
  import hdb3_pkg::*;
#(
  parameter int RUN_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_i,
  input  logic vld_i,
  output sym_t sym_o
);
  localparam int LAST = RUN_LEN - 1;

  sym_t stage_q [RUN_LEN];
  sym_t shifted [RUN_LEN];
  sym_t nxt     [RUN_LEN];
  sym_t incoming;
  logic run_done;
  logic stage_all_zero;

  assign incoming = !vld_i ? SYM_IDLE : (bit_i ? SYM_ONE : SYM_ZERO);

  always_comb begin
    shifted[0] = incoming;
    for (int k = 1; k < RUN_LEN; k++) shifted[k] = stage_q[k-1];
  end

  // A full window of plain zeros is a run that needs substitution.
  always_comb begin
    run_done = 1'b1;
    for (int k = 0; k < RUN_LEN; k++)
      if (shifted[k] != SYM_ZERO) run_done = 1'b0;
  end

  always_comb begin
    for (int k = 0; k < RUN_LEN; k++) nxt[k] = shifted[k];
    if (run_done) begin
      nxt[0]    = SYM_VIOL;
      nxt[LAST] = SYM_SUB;
    end
  end

  for (genvar g = 0; g < RUN_LEN; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[g] <= SYM_IDLE;
      else     stage_q[g] <= nxt[g];
    end
  end

  assign sym_o = stage_q[LAST];

  always_comb begin
    stage_all_zero = 1'b1;
    for (int k = 0; k < RUN_LEN; k++)
      if (stage_q[k] != SYM_ZERO) stage_all_zero = 1'b0;
  end

  // R3: a full run of zeros never survives inside the window
  a_r3_no_zero_run: assert property (@(posedge clk) disable iff (rst)
    !stage_all_zero);
endmodule

// File: rtl/hdb3_polarity.sv
module hdb3_polarity
  import hdb3_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  sym_t sym_i,
  output logic pos_q,
  output logic neg_q
);
  logic mark_pos_q, viol_pos_q;   // 1 = positive polarity
  logic mark_pos_n, viol_pos_n;
  logic emit, pol_pos;

  always_comb begin
    emit       = 1'b0;
    pol_pos    = 1'b0;
    mark_pos_n = mark_pos_q;
    viol_pos_n = viol_pos_q;
    case (sym_i)
      SYM_ONE: begin
        emit       = 1'b1;
        pol_pos    = !mark_pos_q;
        mark_pos_n = !mark_pos_q;
      end
      SYM_SUB: begin
        if (mark_pos_q == viol_pos_q) begin
          emit       = 1'b1;
          pol_pos    = !mark_pos_q;
          mark_pos_n = !mark_pos_q;
        end
      end
      SYM_VIOL: begin
        emit       = 1'b1;
        pol_pos    = mark_pos_q;
        viol_pos_n = mark_pos_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mark_pos_q <= 1'b0;
      viol_pos_q <= 1'b1;
      pos_q      <= 1'b0;
      neg_q      <= 1'b0;
    end else begin
      mark_pos_q <= mark_pos_n;
      viol_pos_q <= viol_pos_n;
      pos_q      <= emit && pol_pos;
      neg_q      <= emit && !pol_pos;
    end
  end

  // R6: a violation is only ever sent opposite to the previous violation
  a_r6_viol_alternates: assert property (@(posedge clk) disable iff (rst)
    (sym_i == SYM_VIOL) |-> (mark_pos_q != viol_pos_q));

  // R9: never both rails
  a_r9_rails_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(pos_q && neg_q));

  // R1: outputs quiet after a reset edge
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    rst |=> (!pos_q && !neg_q));
endmodule

// File: rtl/hdb3_line_encoder.sv
module hdb3_line_encoder
  import hdb3_pkg::*;
#(
  parameter int RUN_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic nrz_i,
  output logic pos_rail_o,
  output logic neg_rail_o
);
  logic smp_bit, smp_vld;
  sym_t out_sym;
  logic pos_q, neg_q;

  hdb3_sampler i_sampler (
    .clk   (clk),
    .rst   (rst),
    .nrz_i (nrz_i),
    .bit_o (smp_bit),
    .vld_o (smp_vld)
  );

  hdb3_lookahead #(.RUN_LEN(RUN_LEN)) i_lookahead (
    .clk   (clk),
    .rst   (rst),
    .bit_i (smp_bit),
    .vld_i (smp_vld),
    .sym_o (out_sym)
  );

  hdb3_polarity i_polarity (
    .clk   (clk),
    .rst   (rst),
    .sym_i (out_sym),
    .pos_q (pos_q),
    .neg_q (neg_q)
  );

  // Return-to-zero: a pulse lasts for the clock high phase only.
  assign pos_rail_o = pos_q & clk;
  assign neg_rail_o = neg_q & clk;
endmodule

// File: tb/test_hdb3_line_encoder.sv
module test_hdb3_line_encoder;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic nrz = 1'b0;
  logic pos_rail, neg_rail;
  int vectors = 0;
  int misses  = 0;

  always #10 clk = ~clk;  // 50 MHz

  hdb3_line_encoder i_hdb3_line_encoder (
    .clk        (clk),
    .rst        (rst),
    .nrz_i      (nrz),
    .pos_rail_o (pos_rail),
    .neg_rail_o (neg_rail)
  );

  function automatic int rail_val();
    return pos_rail ? (neg_rail ? 2 : 1) : (neg_rail ? -1 : 0);
  endfunction

  task automatic check(input string req, input int got, input int exp);
    vectors++;
    if (got != exp) begin
      misses++;
      $display("FAIL %s: rails=%0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  // Applies a pattern (bit i = pat[i]) from reset and checks every symbol.
  task automatic run_case(input logic [127:0] pat, input int len, input string req);
    int expv [0:139];
    int mark, viol, zc, tot;
    tot = len + 5;
    mark = -1; viol = 1; zc = 0;
    for (int i = 0; i < tot; i++) begin
      logic b;
      b = (i < len) ? pat[i] : 1'b0;
      expv[i] = 0;
      if (b) begin
        mark = -mark; expv[i] = mark; zc = 0;
      end else begin
        zc++;
        if (zc == 4) begin
          if (mark == viol) begin
            mark = -mark; expv[i-3] = mark;
          end
          expv[i] = mark; viol = mark; zc = 0;
        end
      end
    end
    @(posedge clk); #2; rst = 1'b1;
    repeat (3) @(posedge clk);
    for (int c = 0; c < tot; c++) begin
      int e;
      @(posedge clk); #2;
      rst = 1'b0;
      nrz = (c < len) ? pat[c] : 1'b0;
      #3;
      e = c - 5;
      check(req, rail_val(), (e >= 0) ? expv[e] : 0);
      check("R9", (pos_rail && neg_rail) ? 1 : 0, 0);
      #10;
      check("R8", rail_val(), 0);
    end
  endtask

  task automatic test_reset();
    // R1: rails quiet while reset held
    @(posedge clk); #2; rst = 1'b1;
    repeat (3) begin
      @(posedge clk); #3;
      check("R1", rail_val(), 0);
    end
    // stream ones, then reset mid-run
    @(posedge clk); #2; rst = 1'b0; nrz = 1'b1;
    repeat (10) @(posedge clk);
    #2; rst = 1'b1;
    repeat (3) begin
      @(posedge clk); #3;
      check("R1", rail_val(), 0);
    end
    nrz = 1'b0;
  endtask

  initial begin
    logic [127:0] lp;
    logic [15:0] l;
    test_reset();
    run_case(128'hFFFF, 16, "R2");          // ones alternate, first positive
    run_case(128'h0, 8, "R5");              // 000V negative, then B00V
    run_case(128'h0, 20, "R6");             // violations alternate
    run_case(128'h1, 5, "R4");              // 1 then B00V
    run_case(128'h21, 9, "R10");            // B updates mark polarity
    run_case(128'h3, 10, "R3");             // 11 then 000V
    run_case(128'h4, 12, "R7");             // single mark timing
    l = 16'hACE1;
    lp = '0;
    for (int i = 0; i < 120; i++) begin
      lp[i] = l[0] & l[3];
      l = {l[14:0], l[15] ^ l[13] ^ l[12] ^ l[10]};
    end
    run_case(lp, 120, "R3");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #4000000;
    misses++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule